// File: doc/BRIEF.md
# Security attribution region checker

This block assigns a security attribute to any 32-bit address: Secure, Non-secure, or Secure and Non-secure-callable. It does this by comparing the address against a parameterised set of programmable windows. Each window has a base and a limit on a 32-byte grain, an enable bit and a callable flag. Software reaches the window table through a register port. A region index register selects which window the base and limit registers address.

The lookup port is purely combinational. It reports the attribute, whether exactly one window matched, and the index of that window. While the unit is switched off, a global default answers every lookup. When a strobe reports an attribution violation, the block raises sticky status flags and captures the faulting address. Software clears each flag by writing one to it.

Top module: `secattr_top`

## Requirements
- R1: After reset the control, index, status and fault-address registers read 0. The register offsets are: control 0xD0, type 0xD4, index 0xD8, base 0xDC, limit 0xE0, status 0xE4, fault address 0xE8. Any other offset reads 0.
- R2: While control bit 0 (unit enable) is 0, lookups return attribute 2'b01 (Non-secure) if control bit 1 is 1, and 2'b00 (Secure) if it is 0. In both cases hit is 0 and the region index is 0. Both control bits read back as written.
- R3: While the unit is enabled, a window matches when {base,5'b00000} <= address <= {limit,5'b11111}. With exactly one match, hit is 1 and the region output gives the window's index. The attribute is then 2'b10 (callable) if that window's limit bit 1 is set, and 2'b01 (Non-secure) if it is clear.
- R4: While the unit is enabled, an address that matches no window, or matches two or more, returns attribute 2'b00 with hit 0 and region 0.
- R5: Limit bit 0 is the window enable. A window whose enable is 0 never matches.
- R6: The index register holds 8 bits. Base and limit accesses go to the window it selects. Base reads back address bits 31:5 with bits 4:0 zero. Limit reads back bits 31:5 plus bits 1:0, with bits 4:2 zero.
- R7: When the index is at or above the number of windows, base and limit writes are ignored and both read 0.
- R8: The type register reads the window count in bits 7:0, and writes to it are ignored.
- R9: Built with zero windows, control bit 0 reads 0 whatever is written.
- R10: A violation strobe sets status bits 3 and 6 and loads the fault address from the strobe's address in the next cycle. Both are sticky. A strobe beats a software write in the same cycle. At other times software may write the fault address.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_addr | input | 32 | Address to classify |
| lk_attr | output | 2 | 00 Secure, 01 Non-secure, 10 Secure callable |
| lk_hit | output | 1 | Exactly one window matched |
| lk_region | output | 8 | Index of the matching window |
| viol_strobe | input | 1 | Attribution violation event |
| viol_addr | input | 32 | Address of the violating access |

## Verification
The bench probes window edges: the first byte of the base grain, the last byte of the limit grain, and one byte outside each. An off-by-one in either bound, or a limit that ignores its implied low ones, changes hit and the attribute there. Overlapping windows must fall back to Secure, so a design that picks a priority winner fails. Out-of-range indices must neither alias onto a real window nor read back stale data. A strobe that arrives together with a clear-all write must leave the flags set, which catches designs that let software clearing win.

// File: rtl/secattr_pkg.sv
package secattr_pkg;
  typedef enum logic [1:0] {
    ATTR_S   = 2'b00,
    ATTR_NS  = 2'b01,
    ATTR_NSC = 2'b10
  } attr_e;

  localparam logic [7:0] OFS_CTRL  = 8'hD0;
  localparam logic [7:0] OFS_TYPE  = 8'hD4;
  localparam logic [7:0] OFS_INDEX = 8'hD8;
  localparam logic [7:0] OFS_BASE  = 8'hDC;
  localparam logic [7:0] OFS_LIMIT = 8'hE0;
  localparam logic [7:0] OFS_STAT  = 8'hE4;
  localparam logic [7:0] OFS_FADDR = 8'hE8;

  localparam logic [7:0] STAT_VIOL_SET = 8'h48;

  typedef struct packed {
    logic [26:0] base;
    logic [26:0] limit;
    logic        nsc;
    logic        en;
  } region_t;
endpackage

// File: rtl/secattr_regions.sv
module secattr_regions
  import secattr_pkg::*;
#(
  parameter int NREG = 8,
  localparam int NS = (NREG > 0) ? NREG : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_limit,
  input  logic [7:0]        idx,
  input  logic [26:0]       wbits,
  input  logic [1:0]        wflags,
  output region_t [NS-1:0]  regs_o
);
  for (genvar i = 0; i < NS; i++) begin : g_reg
    region_t r_q, r_d;
    logic    sel, ld;

    assign sel = (NREG > 0) && (idx == 8'(i));
    assign ld  = sel && (wr_base || wr_limit);

    always_comb begin
      r_d = r_q;
      if (wr_base) r_d.base = wbits;
      if (wr_limit) begin
        r_d.limit = wbits;
        r_d.nsc   = wflags[1];
        r_d.en    = wflags[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r_q <= '0;
      else if (ld) r_q <= r_d;
    end

    assign regs_o[i] = r_q;
  end
endmodule

// File: rtl/secattr_lookup.sv
module secattr_lookup
  import secattr_pkg::*;
#(
  parameter int NREG = 8,
  localparam int NS = (NREG > 0) ? NREG : 1
) (
  input  logic              unit_en,
  input  logic              allns,
  input  region_t [NS-1:0]  regs,
  input  logic [31:0]       addr,
  output logic [1:0]        attr,
  output logic              hit,
  output logic [7:0]        region
);
  logic [NS-1:0] match;

  for (genvar i = 0; i < NS; i++) begin : g_cmp
    assign match[i] = (NREG > 0) && regs[i].en &&
                      (addr >= {regs[i].base, 5'b00000}) &&
                      (addr <= {regs[i].limit, 5'b11111});
  end

  logic [8:0] cnt;
  logic [7:0] last;
  logic       last_nsc;

  always_comb begin
    cnt      = '0;
    last     = '0;
    last_nsc = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (match[i]) begin
        cnt      = cnt + 9'd1;
        last     = 8'(i);
        last_nsc = regs[i].nsc;
      end
    end
  end

  always_comb begin
    attr   = ATTR_S;
    hit    = 1'b0;
    region = '0;
    if (!unit_en) begin
      attr = allns ? ATTR_NS : ATTR_S;
    end else if (cnt == 9'd1) begin
      attr   = last_nsc ? ATTR_NSC : ATTR_NS;
      hit    = 1'b1;
      region = last;
    end
  end
endmodule

// File: rtl/secattr_fault.sv
module secattr_fault
  import secattr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stat,
  input  logic        wr_faddr,
  input  logic [31:0] wdata,
  input  logic        viol,
  input  logic [31:0] viol_addr,
  output logic [7:0]  stat_q,
  output logic [31:0] faddr_q
);
  logic [7:0]  stat_d;
  logic [31:0] faddr_d;
  logic        stat_ce, faddr_ce;

  assign stat_ce  = wr_stat || viol;
  assign faddr_ce = wr_faddr || viol;

  always_comb begin
    stat_d = stat_q;
    if (wr_stat) stat_d = stat_d & ~wdata[7:0];
    if (viol)    stat_d = stat_d | STAT_VIOL_SET;
    faddr_d = viol ? viol_addr : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_ce) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        faddr_q <= '0;
    else if (faddr_ce) faddr_q <= faddr_d;
  end
endmodule

// File: rtl/secattr_top.sv
module secattr_top
  import secattr_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] lk_addr,
  output logic [1:0]  lk_attr,
  output logic        lk_hit,
  output logic [7:0]  lk_region,
  input  logic        viol_strobe,
  input  logic [31:0] viol_addr
);
  localparam int NS = (NREG > 0) ? NREG : 1;
  localparam logic [8:0] NREG9 = 9'(NREG);

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic wr_ctrl, wr_index, wr_base, wr_limit, wr_stat, wr_faddr;
  assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
  assign wr_index = reg_we && (reg_addr == OFS_INDEX);
  assign wr_base  = reg_we && (reg_addr == OFS_BASE);
  assign wr_limit = reg_we && (reg_addr == OFS_LIMIT);
  assign wr_stat  = reg_we && (reg_addr == OFS_STAT);
  assign wr_faddr = reg_we && (reg_addr == OFS_FADDR);

  logic       ctrl_en_q, ctrl_en_d, ctrl_allns_q, ctrl_allns_d;
  logic [7:0] idx_q, idx_d;

  always_comb begin
    ctrl_en_d    = (NREG > 0) && reg_wdata[0];
    ctrl_allns_d = reg_wdata[1];
    idx_d        = reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_en_q    <= 1'b0;
      ctrl_allns_q <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en_q    <= ctrl_en_d;
      ctrl_allns_q <= ctrl_allns_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      idx_q <= '0;
    else if (wr_index) idx_q <= idx_d;
  end

  region_t [NS-1:0] regs;
  logic             idx_valid;
  assign idx_valid = ({1'b0, idx_q} < NREG9);

  secattr_regions #(.NREG(NREG)) u_regions (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_base  (wr_base && idx_valid),
    .wr_limit (wr_limit && idx_valid),
    .idx      (idx_q),
    .wbits    (reg_wdata[31:5]),
    .wflags   (reg_wdata[1:0]),
    .regs_o   (regs)
  );

  secattr_lookup #(.NREG(NREG)) u_lookup (
    .unit_en (ctrl_en_q),
    .allns   (ctrl_allns_q),
    .regs    (regs),
    .addr    (lk_addr),
    .attr    (lk_attr),
    .hit     (lk_hit),
    .region  (lk_region)
  );

  logic [7:0]  stat_q;
  logic [31:0] faddr_q;

  secattr_fault u_fault (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_stat   (wr_stat),
    .wr_faddr  (wr_faddr),
    .wdata     (reg_wdata),
    .viol      (viol_strobe),
    .viol_addr (viol_addr),
    .stat_q    (stat_q),
    .faddr_q   (faddr_q)
  );

  region_t sel_reg;
  always_comb begin
    sel_reg = '0;
    for (int i = 0; i < NS; i++) begin
      if (idx_valid && ({1'b0, idx_q} == 9'(i))) sel_reg = regs[i];
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFS_CTRL:  reg_rdata = {30'b0, ctrl_allns_q, ctrl_en_q};
      OFS_TYPE:  reg_rdata = {24'b0, NREG9[7:0]};
      OFS_INDEX: reg_rdata = {24'b0, idx_q};
      OFS_BASE:  reg_rdata = {sel_reg.base, 5'b0};
      OFS_LIMIT: reg_rdata = {sel_reg.limit, 3'b0, sel_reg.nsc, sel_reg.en};
      OFS_STAT:  reg_rdata = {24'b0, stat_q};
      OFS_FADDR: reg_rdata = faddr_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

module secattr_chk
  import secattr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        clr_bit3,
  input logic        viol_strobe,
  input logic [31:0] viol_addr,
  input logic [7:0]  stat_q,
  input logic [31:0] faddr_q,
  input logic        ctrl_en,
  input logic        ctrl_allns,
  input logic [1:0]  lk_attr,
  input logic        lk_hit
);
  p_viol_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_strobe |=> (stat_q[3] && stat_q[6] && faddr_q == $past(viol_addr)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !clr_bit3) |=> stat_q[3]);

  p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bit3 && !viol_strobe) |=> !stat_q[3]);

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!lk_hit && lk_attr == (ctrl_allns ? ATTR_NS : ATTR_S)));

  p_miss_secure_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !lk_hit) |-> (lk_attr == ATTR_S));

  p_hit_attr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_attr == ATTR_NS || lk_attr == ATTR_NSC));
endmodule

bind secattr_top secattr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .clr_bit3    (wr_stat && reg_wdata[3]),
  .viol_strobe (viol_strobe),
  .viol_addr   (viol_addr),
  .stat_q      (stat_q),
  .faddr_q     (faddr_q),
  .ctrl_en     (ctrl_en_q),
  .ctrl_allns  (ctrl_allns_q),
  .lk_attr     (lk_attr),
  .lk_hit      (lk_hit)
);

// File: tb/tb_secattr_top.sv
module tb_secattr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_we = 1'b0, viol_strobe = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0, lk_addr = '0, viol_addr = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  lk_attr;
  logic        lk_hit;
  logic [7:0]  lk_region;

  logic        z_we = 1'b0;
  logic [7:0]  z_addr = 8'h00;
  logic [31:0] z_wdata = '0;
  logic [31:0] z_rdata;
  logic [1:0]  z_attr;
  logic        z_hit;
  logic [7:0]  z_region;

  secattr_top #(.NREG(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_attr(lk_attr), .lk_hit(lk_hit), .lk_region(lk_region),
    .viol_strobe(viol_strobe), .viol_addr(viol_addr));

  secattr_top #(.NREG(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .reg_we(z_we), .reg_addr(z_addr),
    .reg_wdata(z_wdata), .reg_rdata(z_rdata), .lk_addr(32'h0000_1000),
    .lk_attr(z_attr), .lk_hit(z_hit), .lk_region(z_region),
    .viol_strobe(1'b0), .viol_addr(32'h0));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #2;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic look(input string tag, input logic [31:0] a, input logic [1:0] ea,
                      input logic eh, input logic [7:0] er);
    lk_addr = a;
    #2;
    chk(tag, {21'b0, lk_hit, lk_region, lk_attr}, {21'b0, eh, er, ea});
  endtask

  task automatic t_reset;
    rd("R1 ctrl", 8'hD0, 32'h0);
    rd("R1 index", 8'hD8, 32'h0);
    rd("R1 status", 8'hE4, 32'h0);
    rd("R1 faddr", 8'hE8, 32'h0);
    rd("R1 unused offset", 8'hEC, 32'h0);
    look("R2 off secure default", 32'h0000_1000, 2'b00, 1'b0, 8'd0);
  endtask

  task automatic t_disabled;
    wr(8'hD0, 32'h2);
    rd("R2 ctrl readback", 8'hD0, 32'h2);
    look("R2 off non-secure default", 32'h0000_1000, 2'b01, 1'b0, 8'd0);
  endtask

  task automatic t_type;
    wr(8'hD4, 32'hFF);
    rd("R8 type count", 8'hD4, 32'h8);
  endtask

  task automatic t_program;
    wr(8'hD8, 32'h0);
    wr(8'hDC, 32'h0000_101F);
    wr(8'hE0, 32'h0000_1FFD);
    rd("R6 base low bits zero", 8'hDC, 32'h0000_1000);
    rd("R6 limit readback", 8'hE0, 32'h0000_1FE1);
    wr(8'hD8, 32'h1);
    wr(8'hDC, 32'h0000_3000);
    wr(8'hE0, 32'h0000_30E3);
    rd("R6 second window base", 8'hDC, 32'h0000_3000);
    wr(8'hD0, 32'h1);
    look("R3 base edge", 32'h0000_1000, 2'b01, 1'b1, 8'd0);
    look("R3 limit edge", 32'h0000_1FFF, 2'b01, 1'b1, 8'd0);
    look("R4 below base", 32'h0000_0FFF, 2'b00, 1'b0, 8'd0);
    look("R4 above limit", 32'h0000_2000, 2'b00, 1'b0, 8'd0);
    look("R3 callable window", 32'h0000_30FF, 2'b10, 1'b1, 8'd1);
    look("R4 past callable", 32'h0000_3100, 2'b00, 1'b0, 8'd0);
  endtask

  task automatic t_overlap;
    wr(8'hD8, 32'h2);
    wr(8'hDC, 32'h0000_1800);
    wr(8'hE0, 32'h0000_18E1);
    look("R4 overlap secure", 32'h0000_1810, 2'b00, 1'b0, 8'd0);
    look("R4 single outside overlap", 32'h0000_1000, 2'b01, 1'b1, 8'd0);
    wr(8'hE0, 32'h0000_18E0);
    look("R5 disabled window ignored", 32'h0000_1810, 2'b01, 1'b1, 8'd0);
  endtask

  task automatic t_range;
    wr(8'hD8, 32'h9);
    rd("R6 index readback", 8'hD8, 32'h9);
    wr(8'hDC, 32'hFFFF_FFE0);
    wr(8'hE0, 32'hFFFF_FFE1);
    rd("R7 base reads zero", 8'hDC, 32'h0);
    rd("R7 limit reads zero", 8'hE0, 32'h0);
    look("R7 write ignored", 32'hFFFF_FFF0, 2'b00, 1'b0, 8'd0);
    wr(8'hD8, 32'h0);
    rd("R7 no alias on window 0", 8'hDC, 32'h0000_1000);
  endtask

  task automatic t_fault;
    @(negedge clk);
    viol_strobe = 1'b1; viol_addr = 32'hDEAD_BEEF;
    @(negedge clk);
    viol_strobe = 1'b0;
    rd("R10 flags set", 8'hE4, 32'h48);
    rd("R10 address captured", 8'hE8, 32'hDEAD_BEEF);
    wr(8'hE4, 32'h08);
    rd("R11 clear bit 3 only", 8'hE4, 32'h40);
    wr(8'hE4, 32'h0);
    rd("R11 zero write keeps", 8'hE4, 32'h40);
    @(negedge clk);
    viol_strobe = 1'b1; viol_addr = 32'h1234_5678;
    reg_we = 1'b1; reg_addr = 8'hE4; reg_wdata = 32'hFF;
    @(negedge clk);
    viol_strobe = 1'b0; reg_we = 1'b0;
    rd("R10 strobe beats clear", 8'hE4, 32'h48);
    rd("R10 new address", 8'hE8, 32'h1234_5678);
    wr(8'hE4, 32'h48);
    rd("R11 all cleared", 8'hE4, 32'h0);
    wr(8'hE8, 32'h0000_0055);
    rd("R10 software address write", 8'hE8, 32'h0000_0055);
  endtask

  task automatic t_zero;
    @(negedge clk);
    z_we = 1'b1; z_addr = 8'hD0; z_wdata = 32'h3;
    @(negedge clk);
    z_we = 1'b0;
    #2;
    chk("R9 enable stuck low", z_rdata, 32'h2);
    z_addr = 8'hD4;
    #2;
    chk("R8 zero count", z_rdata, 32'h0);
    chk("R9 lookup uses default", {29'b0, z_hit, z_attr}, {29'b0, 1'b0, 2'b01});
    chk("R9 region index", {24'b0, z_region}, 32'h0);
  endtask

  initial begin
    #1000;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_type;
    t_program;
    t_overlap;
    t_range;
    t_fault;
    t_zero;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule